// File: doc/BRIEF.md
# NAND Tree Connectivity Test Logic

This block provides a board-level connectivity test for a bus-interface chip. While the active-low reset pin is held low and the power-good input is high, the block enters a test mode. In test mode every pad that takes part in the test becomes an input. A chain of two-input NAND stages then combines the reset pin and the pads in a fixed order. The chain result replaces the normal interrupt on the interrupt pin.

A tester holds reset low and all other chain pads high, then pulls the pads low one at a time in chain order. Each additional low pad toggles the interrupt pin, so the pin produces a square wave. A pad that is open, shorted or stuck breaks the expected pattern at its own step, and that step identifies the faulty pad.

The chain is purely combinational and has no clock. The clock pin is one of the chain inputs, so the chain cannot depend on it. Outside test mode the block is transparent: the core's output enables pass through unchanged, and the interrupt pin carries the normal active-low interrupt.

Top module: `nand_tree_test`

## Requirements
- R1: Test mode is active exactly when rst_ni is 0 and pwr_good_i is 1. Any other combination is normal mode.
- R2: In test mode every bit of pad_oe_o is 0, whatever core_oe_i holds.
- R3: In normal mode pad_oe_o equals core_oe_i bit for bit.
- R4: In normal mode int_o equals irq_ni.
- R5: The chain order is fixed as follows. Chain index 0 is rst_ni, and chain index i+1 is pad_i[i]. pad_i[0] is the clock pad, pad_i[1] is the bus-grant pad, and pad_i[N_PADS-1] is the address/EEPROM pad. N_PADS must be even, which makes the chain length odd.
- R6: In test mode with every pad_i bit at 1, int_o is 1.
- R7: In test mode, when pad_i[0] through pad_i[k-1] are 0 and the remaining pads are 1, int_o is 1 for even k and 0 for odd k. The first pad falling drives int_o low, and the second pad falling drives it high again.
- R8: In test mode with every pad_i bit at 0, int_o is 1.
- R9: In test mode with any pad pattern, let j be the highest chain index whose input is 0. int_o is 1 when N_PADS - j is even and 0 otherwise. A pad stuck high during the walk therefore shifts the square wave.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Active-low reset pin; chain input 0 and test-mode request |
| pwr_good_i | input | 1 | Power-good; must be high for test mode |
| pad_i | input | N_PADS | Pad input levels, in chain order after reset |
| core_oe_i | input | N_PADS | Output-enable requests from the core, per pad |
| irq_ni | input | 1 | Normal active-low interrupt from the core |
| pad_oe_o | output | N_PADS | Output enables applied to the pads |
| int_o | output | 1 | Level driven onto the interrupt pin |

## Verification
The bench builds two copies of the block. The first uses N_PADS = 10, which gives a chain of eleven inputs, so a full walk produces five complete toggle periods and a stuck pad can be placed well inside the chain. The second uses N_PADS = 2, the shortest legal chain, where the clock and grant pads are also the last stages and any off-by-one error in the seed or the tap order shows up at once. Random pad, enable and interrupt patterns in both modes are checked against a model based on the last low chain input. This model is a different formulation from the NAND fold the RTL uses.

// File: rtl/nt_pkg.sv
package nt_pkg;
  typedef enum logic {
    SRC_CORE  = 1'b0,
    SRC_CHAIN = 1'b1
  } int_src_e;
endpackage

// File: rtl/nt_mode.sv
module nt_mode
  import nt_pkg::*;
(
  input  logic     rst_ni,
  input  logic     pwr_good_i,
  output logic     test_o,
  output int_src_e src_o
);
  assign test_o = ~rst_ni & pwr_good_i;
  assign src_o  = test_o ? SRC_CHAIN : SRC_CORE;
endmodule

// File: rtl/nt_chain.sv
module nt_chain #(
  parameter int N_IN = 3
) (
  input  logic [N_IN-1:0] in_i,
  output logic            out_o
);
  logic [N_IN-1:0] stg;

  // first stage seeded with 1
  assign stg[0] = ~(1'b1 & in_i[0]);

  for (genvar i = 1; i < N_IN; i++) begin : g_stage
    assign stg[i] = ~(stg[i-1] & in_i[i]);
  end

  assign out_o = stg[N_IN-1];
endmodule

// File: rtl/nt_oe_gate.sv
module nt_oe_gate #(
  parameter int N = 2
) (
  input  logic         test_i,
  input  logic [N-1:0] core_oe_i,
  output logic [N-1:0] oe_o
);
  for (genvar i = 0; i < N; i++) begin : g_oe
    assign oe_o[i] = core_oe_i[i] & ~test_i;
  end
endmodule

// File: rtl/nt_out_mux.sv
module nt_out_mux
  import nt_pkg::*;
(
  input  int_src_e sel_i,
  input  logic     core_i,
  input  logic     chain_i,
  output logic     out_o
);
  always_comb begin
    unique case (sel_i)
      SRC_CHAIN: out_o = chain_i;
      default:   out_o = core_i;
    endcase
  end
endmodule

// File: rtl/nand_tree_test.sv
module nand_tree_test
  import nt_pkg::*;
#(
  parameter int N_PADS = 10
) (
  input  logic              rst_ni,
  input  logic              pwr_good_i,
  input  logic [N_PADS-1:0] pad_i,
  input  logic [N_PADS-1:0] core_oe_i,
  input  logic              irq_ni,
  output logic [N_PADS-1:0] pad_oe_o,
  output logic              int_o
);
  localparam int NChain = N_PADS + 1;

  logic            test;
  int_src_e        src;
  logic            chain_out;
  logic [NChain-1:0] chain_in;

  assign chain_in = {pad_i, rst_ni};

  nt_mode u_mode (
    .rst_ni    (rst_ni),
    .pwr_good_i(pwr_good_i),
    .test_o    (test),
    .src_o     (src)
  );

  nt_chain #(.N_IN(NChain)) u_chain (
    .in_i (chain_in),
    .out_o(chain_out)
  );

  nt_oe_gate #(.N(N_PADS)) u_oe (
    .test_i   (test),
    .core_oe_i(core_oe_i),
    .oe_o     (pad_oe_o)
  );

  nt_out_mux u_mux (
    .sel_i  (src),
    .core_i (irq_ni),
    .chain_i(chain_out),
    .out_o  (int_o)
  );
endmodule

// File: rtl/nand_tree_test_chk.sv
module nand_tree_test_chk #(
  parameter int N_PADS = 10
) (
  input logic              rst_ni,
  input logic              pwr_good_i,
  input logic [N_PADS-1:0] pad_i,
  input logic [N_PADS-1:0] core_oe_i,
  input logic              irq_ni,
  input logic [N_PADS-1:0] pad_oe_o,
  input logic              int_o
);
  logic tm;
  int   last_low;
  logic exp_chain;

  always_comb begin
    tm = ~rst_ni & pwr_good_i;
    last_low = 0;
    for (int i = 0; i < N_PADS; i++) if (!pad_i[i]) last_low = i + 1;
    exp_chain = ((N_PADS - last_low) % 2) == 0;
  end

  always_comb begin
    if (tm) begin
      a_r2_oe_off: assert (pad_oe_o == '0);
      a_r6_all_high: assert (!(&pad_i) || int_o);
      a_r8_all_low: assert ((|pad_i) || int_o);
      a_r9_last_low: assert (int_o == exp_chain);
    end else begin
      a_r3_oe_pass: assert (pad_oe_o == core_oe_i);
      a_r4_irq_pass: assert (int_o == irq_ni);
    end
  end
endmodule

bind nand_tree_test nand_tree_test_chk #(.N_PADS(N_PADS)) u_chk (
  .rst_ni    (rst_ni),
  .pwr_good_i(pwr_good_i),
  .pad_i     (pad_i),
  .core_oe_i (core_oe_i),
  .irq_ni    (irq_ni),
  .pad_oe_o  (pad_oe_o),
  .int_o     (int_o)
);

// File: tb/sim_nand_tree_test.sv
`timescale 1ns/1ps
module sim_nand_tree_test;
  localparam int NA = 10;
  localparam int NB = 2;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n, pg, irq_a, irq_b;
  logic [NA-1:0] pad_a, oe_req_a, oe_a;
  logic [NB-1:0] pad_b, oe_req_b, oe_b;
  logic          int_a, int_b;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  nand_tree_test #(.N_PADS(NA)) u0 (
    .rst_ni(rst_n), .pwr_good_i(pg), .pad_i(pad_a), .core_oe_i(oe_req_a),
    .irq_ni(irq_a), .pad_oe_o(oe_a), .int_o(int_a)
  );

  nand_tree_test #(.N_PADS(NB)) u1 (
    .rst_ni(rst_n), .pwr_good_i(pg), .pad_i(pad_b), .core_oe_i(oe_req_b),
    .irq_ni(irq_b), .pad_oe_o(oe_b), .int_o(int_b)
  );

  // last-low model: j = highest low chain index (reset is index 0)
  function automatic logic model(input logic [15:0] pads, input int n);
    int j = 0;
    for (int i = 0; i < n; i++) if (!pads[i]) j = i + 1;
    return ((n - j) % 2) == 0;
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic settle();
    @(negedge clk);
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic ideal, stuck_m;
    bit   diverged;
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b1; pg = 1'b1; irq_a = 1'b1; irq_b = 1'b0;
    pad_a = '1; pad_b = '1;
    oe_req_a = 10'h2a5; oe_req_b = 2'b10;
    settle();
    // R3 R4: normal mode transparency
    chk("R3 oe pass a", 16'(oe_a), 16'(oe_req_a));
    chk("R4 irq pass a", 16'(int_a), 16'(irq_a));
    chk("R4 irq pass b", 16'(int_b), 16'(irq_b));

    // R1: reset low but no power-good stays normal
    rst_n = 1'b0; pg = 1'b0; irq_a = 1'b0;
    settle();
    chk("R1 no pg oe", 16'(oe_a), 16'(oe_req_a));
    chk("R1 no pg irq", 16'(int_a), 16'h0);

    // R2 R6: enter test mode, all pads high
    pg = 1'b1;
    settle();
    chk("R2 oe forced a", 16'(oe_a), 16'h0);
    chk("R2 oe forced b", 16'(oe_b), 16'h0);
    chk("R6 all high a", 16'(int_a), 16'h1);
    chk("R6 all high b", 16'(int_b), 16'h1);

    // R5 R7: walk pads low in chain order
    for (int k = 1; k <= NA; k++) begin
      pad_a[k-1] = 1'b0;
      settle();
      chk($sformatf("R7 R5 walk a k=%0d", k), 16'(int_a), 16'((k % 2) == 0));
    end
    chk("R8 all low a", 16'(int_a), 16'h1);
    for (int k = 1; k <= NB; k++) begin
      pad_b[k-1] = 1'b0;
      settle();
      chk($sformatf("R7 walk b k=%0d", k), 16'(int_b), 16'((k % 2) == 0));
    end
    chk("R8 all low b", 16'(int_b), 16'h1);

    // R9: pad 3 stuck high during the walk shifts the pattern
    pad_a = '1;
    diverged = 1'b0;
    for (int k = 1; k <= NA; k++) begin
      if (k - 1 != 3) pad_a[k-1] = 1'b0;
      settle();
      ideal   = (k % 2) == 0;
      stuck_m = model(16'(pad_a), NA);
      if (ideal != stuck_m) diverged = 1'b1;
      chk($sformatf("R9 stuck walk k=%0d", k), 16'(int_a), 16'(stuck_m));
    end
    chk("R9 stuck pad detectable", 16'(diverged), 16'h1);

    // R1 R2 R3 R4 R9: random mix of modes and patterns
    for (int it = 0; it < 300; it++) begin
      logic tm;
      rst_n    = 1'($urandom);
      pg       = 1'($urandom);
      pad_a    = NA'($urandom);
      pad_b    = NB'($urandom);
      oe_req_a = NA'($urandom);
      oe_req_b = NB'($urandom);
      irq_a    = 1'($urandom);
      irq_b    = 1'($urandom);
      settle();
      tm = !rst_n && pg;
      chk("R1 R2 R3 rnd oe a", 16'(oe_a), tm ? 16'h0 : 16'(oe_req_a));
      chk("R1 R2 R3 rnd oe b", 16'(oe_b), tm ? 16'h0 : 16'(oe_req_b));
      chk("R4 R9 rnd int a", 16'(int_a), tm ? 16'(model(16'(pad_a), NA)) : 16'(irq_a));
      chk("R4 R9 rnd int b", 16'(int_b), tm ? 16'(model(16'(pad_b), NB)) : 16'(irq_b));
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule